// File: doc/BRIEF.md
# SPI Serial Clock Generator with Selectable Divide Law

This block makes the serial clock for an SPI master out of a faster module clock. A static clock-control word selects one of two division laws. The linear law divides by an even number, 2·(N+1). The exponential law divides by a power of two, 2^M. Alongside the serial clock, the block gives the shift engine a one-cycle strobe at each edge that leaves the polarity level (leading) and at each edge that returns to it (trailing).

A transfer starts when the run input goes high and lasts until it goes low. While the block is stopped, the serial clock rests at the polarity level. The block samples the divider setting and the polarity only while it is stopped. A change made during a transfer is therefore held off until the block is idle again, so no shortened high or low phase can reach the line. When run drops while the clock is away from its rest level, the block completes that half-period and ends with a normal trailing edge.

Top module: `spick_gen`

## Requirements
- R1: While reset is asserted, sck_o is 0 and both lead_o and trail_o are 0, whatever the polarity input.
- R2: While idle, sck_o takes the value cpol_i had at the previous rising clock edge, and no strobe is raised.
- R3: With mode bit clk_cfg_i[12]=1, the clock follows the linear law. Each half-period lasts N+1 module clocks, where N = clk_cfg_i[7:0].
- R4: With clk_cfg_i[12]=0 and M = clk_cfg_i[11:8] of at least 1, each half-period lasts 2^(M-1) module clocks.
- R5: In the exponential law, M=0 gives the same divide-by-2 as M=1, so each half-period is one module clock.
- R6: Only bit 12 selects the law. The same N and M fields give the linear timing with bit 12 set and the exponential timing with it clear.
- R7: The first rising clock edge that samples run_i high starts the transfer. The first serial clock edge appears one half-period later.
- R8: Every serial clock edge comes with exactly one single-cycle strobe, in the same cycle as the change on sck_o. lead_o marks a move away from the polarity level and trail_o a return to it; the two are never high together.
- R9: Changes to clk_cfg_i or cpol_i during a transfer do not alter its timing or its levels.
- R10: If run_i drops while sck_o is away from the rest level, one trailing edge follows a full half-period after the previous edge, and no leading edge follows. If run_i drops at the rest level, no further edge follows.
- R11: Linear mode with N=0 is the fastest setting: sck_o toggles on every module clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cfg_i | input | 13 | Divider word: [7:0] linear count, [11:8] exponent, [12] law select |
| cpol_i | input | 1 | Rest level of the serial clock |
| run_i | input | 1 | Transfer enable |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe on each edge leaving the rest level |
| trail_o | output | 1 | One-cycle strobe on each edge returning to the rest level |

## Verification
A half-period counter that is off by one, or a divider value decoded wrongly, moves the first edge of the next transfer away from its computed cycle. That edge appears within one half-period of the start. The strobes are checked against exact expected cycles, so a one-cycle shift is seen at the first edge. A state machine that fails to hold or drain shows up after the cycle in which run falls: either an extra leading strobe appears, or the expected trailing strobe is missing.

// File: rtl/spick_pkg.sv
package spick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } spick_st_e;

    function automatic int unsigned spick_term_width(input int unsigned lin_w,
                                                     input int unsigned pow_w);
        int unsigned pw;
        pw = (1 << pow_w) - 1;
        return (lin_w > pw) ? lin_w : pw;
    endfunction

endpackage

// File: rtl/spick_decode.sv
module spick_decode #(
    parameter int unsigned LIN_W  = 8,
    parameter int unsigned POW_W  = 4,
    parameter int unsigned HALF_W = 15
) (
    input  logic [LIN_W+POW_W:0] cfg_i,
    output logic [HALF_W-1:0]    term_o
);
    localparam int unsigned SEL_BIT = LIN_W + POW_W;

    logic [LIN_W-1:0]  lin_n;
    logic [POW_W-1:0]  pow_m;
    logic [POW_W-1:0]  pow_sh;
    logic [HALF_W-1:0] one_h;

    always_comb begin
        lin_n  = cfg_i[LIN_W-1:0];
        pow_m  = cfg_i[LIN_W +: POW_W];
        one_h  = HALF_W'(1);
        pow_sh = (pow_m == '0) ? '0 : pow_m - POW_W'(1);
        if (cfg_i[SEL_BIT]) begin
            term_o = HALF_W'(lin_n);
        end else begin
            term_o = (one_h << pow_sh) - one_h;
        end
    end
endmodule

// File: rtl/spick_halfcnt.sv
module spick_halfcnt #(
    parameter int unsigned HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [HALF_W-1:0] term_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
    } cnt_s;

    cnt_s cnt_d, cnt_q;

    always_comb begin
        cnt_d.cnt = '0;
        tick_o    = en_i && (cnt_q.cnt == term_i);
        if (en_i && !tick_o) begin
            cnt_d.cnt = cnt_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.cnt <= term_i);

    p_cnt_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> cnt_q.cnt == '0);
endmodule

// File: rtl/spick_ctrl.sv
module spick_ctrl
    import spick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic cnt_en_o,
    output logic idle_o,
    output logic phase_o,
    output logic lead_o,
    output logic trail_o
);
    typedef struct packed {
        spick_st_e st;
        logic      phase;
        logic      lead;
        logic      trail;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.lead  = 1'b0;
        ctl_d.trail = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.phase = 1'b0;
                if (run_i) begin
                    ctl_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!run_i) begin
                    if (ctl_q.phase && tick_i) begin
                        ctl_d.phase = 1'b0;
                        ctl_d.trail = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end else if (ctl_q.phase) begin
                        ctl_d.st = ST_DRAIN;
                    end else begin
                        ctl_d.st = ST_IDLE;
                    end
                end else if (tick_i) begin
                    ctl_d.phase = ~ctl_q.phase;
                    ctl_d.lead  = ~ctl_q.phase;
                    ctl_d.trail = ctl_q.phase;
                end
            end
            ST_DRAIN: begin
                if (tick_i) begin
                    ctl_d.phase = 1'b0;
                    ctl_d.trail = 1'b1;
                    ctl_d.st    = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st    = ST_IDLE;
                ctl_d.phase = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, phase: 1'b0, lead: 1'b0, trail: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cnt_en_o = (ctl_q.st != ST_IDLE);
    assign idle_o   = (ctl_q.st == ST_IDLE);
    assign phase_o  = ctl_q.phase;
    assign lead_o   = ctl_q.lead;
    assign trail_o  = ctl_q.trail;

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_o && trail_o));

    p_lead_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o == $rose(phase_o));

    p_trail_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o == $fell(phase_o));

    p_idle_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> !phase_o);

    p_no_lead_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |-> $past(run_i));
endmodule

// File: rtl/spick_gen.sv
module spick_gen
    import spick_pkg::*;
#(
    parameter int unsigned LIN_W = 8,
    parameter int unsigned POW_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LIN_W+POW_W:0] clk_cfg_i,
    input  logic                 cpol_i,
    input  logic                 run_i,
    output logic                 sck_o,
    output logic                 lead_o,
    output logic                 trail_o
);
    localparam int unsigned HALF_W = spick_term_width(LIN_W, POW_W);

    typedef struct packed {
        logic [HALF_W-1:0] term;
        logic              pol;
    } cfg_s;

    cfg_s              cfg_d, cfg_q;
    logic [HALF_W-1:0] dec_term;
    logic              tick;
    logic              cnt_en;
    logic              idle;
    logic              phase;

    spick_decode #(
        .LIN_W (LIN_W),
        .POW_W (POW_W),
        .HALF_W(HALF_W)
    ) u_decode (
        .cfg_i (clk_cfg_i),
        .term_o(dec_term)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (idle) begin
            cfg_d.term = dec_term;
            cfg_d.pol  = cpol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    spick_halfcnt #(
        .HALF_W(HALF_W)
    ) u_halfcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cnt_en),
        .term_i(cfg_q.term),
        .tick_o(tick)
    );

    spick_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_i),
        .tick_i  (tick),
        .cnt_en_o(cnt_en),
        .idle_o  (idle),
        .phase_o (phase),
        .lead_o  (lead_o),
        .trail_o (trail_o)
    );

    assign sck_o = cfg_q.pol ^ phase;

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cfg_q));

    p_sck_moves_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle) && (sck_o != $past(sck_o))) |-> (lead_o || trail_o));
endmodule

// File: tb/test_spick_gen.sv
`timescale 1ns/1ps
module test_spick_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] clk_cfg_i = '0;
    logic        cpol_i = 1'b0;
    logic        run_i = 1'b0;
    logic        sck_o, lead_o, trail_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    lead;
        bit    lvl;
        string req;
    } exp_t;

    exp_t exp_q[$];

    spick_gen i_spick_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_cfg_i(clk_cfg_i),
        .cpol_i   (cpol_i),
        .run_i    (run_i),
        .sck_o    (sck_o),
        .lead_o   (lead_o),
        .trail_o  (trail_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic int exp_half(input logic [12:0] cfg);
        int m;
        if (cfg[12]) return int'(cfg[7:0]) + 1;
        m = int'(cfg[11:8]);
        if (m == 0) return 1;
        return 1 << (m - 1);
    endfunction

    always @(negedge clk) begin
        if (rst_n && (lead_o || trail_o)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", $sformatf("unexpected edge at cycle %0d: lead=%0b trail=%0b, expected none",
                      cyc, lead_o, trail_o));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.at && lead_o == e.lead && trail_o == !e.lead && sck_o == e.lvl, e.req,
                      $sformatf("edge actual cycle=%0d lead=%0b trail=%0b sck=%0b, expected cycle=%0d lead=%0b trail=%0b sck=%0b",
                                cyc, lead_o, trail_o, sck_o, e.at, e.lead, !e.lead, e.lvl));
            end
        end
    end

    task automatic burst(input logic [12:0] cfg, input bit pol, input int nedg,
                         input string req, input bit perturb);
        int half, c0, ne, drop;
        half = exp_half(cfg);
        @(negedge clk);
        clk_cfg_i = cfg;
        cpol_i    = pol;
        repeat (3) @(negedge clk);
        c0 = cyc;
        ne = (nedg % 2 == 0) ? nedg : nedg + 1;
        for (int i = 0; i < ne; i++) begin
            exp_q.push_back('{at: c0 + 1 + half * (i + 1), lead: (i % 2 == 0),
                              lvl: (i % 2 == 0) ? !pol : pol, req: req});
        end
        run_i = 1'b1;
        drop = c0 + 1 + half * nedg;
        if (perturb) begin
            repeat (2) @(negedge clk);
            clk_cfg_i = 13'h1000;
            cpol_i    = !pol;
        end
        while (cyc != drop) @(negedge clk);
        run_i = 1'b0;
        repeat (half + 3) @(negedge clk);
        check(exp_q.size() == 0, req,
              $sformatf("pending edges actual=%0d expected=0", exp_q.size()));
        exp_q.delete();
    endtask

    initial begin
        cpol_i = 1'b1;
        repeat (3) @(negedge clk);
        check(sck_o == 1'b0 && !lead_o && !trail_o, "R1",
              $sformatf("reset sck=%0b lead=%0b trail=%0b expected 0 0 0", sck_o, lead_o, trail_o));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sck_o == 1'b1 && !lead_o && !trail_o, "R2",
              $sformatf("idle sck=%0b expected 1", sck_o));
        cpol_i = 1'b0;
        repeat (2) @(negedge clk);
        check(sck_o == 1'b0 && !lead_o && !trail_o, "R2",
              $sformatf("idle sck=%0b expected 0", sck_o));

        burst(13'h1000, 1'b0, 6, "R11", 1'b0);
        burst(13'h1005, 1'b0, 4, "R3", 1'b0);
        burst(13'h1005, 1'b1, 4, "R7", 1'b0);
        burst(13'h10FF, 1'b0, 2, "R3", 1'b0);
        burst(13'h0300, 1'b0, 4, "R4", 1'b0);
        burst(13'h0F00, 1'b1, 2, "R4", 1'b0);
        burst(13'h0000, 1'b0, 4, "R5", 1'b0);
        burst(13'h0100, 1'b1, 4, "R5", 1'b0);
        burst(13'h1503, 1'b0, 4, "R6", 1'b0);
        burst(13'h0503, 1'b0, 4, "R6", 1'b0);
        burst(13'h1009, 1'b0, 6, "R9", 1'b1);
        burst(13'h1006, 1'b0, 3, "R10", 1'b0);
        burst(13'h1000, 1'b1, 3, "R10", 1'b0);
        burst(13'h0200, 1'b0, 5, "R10", 1'b0);

        cpol_i = 1'b1;
        repeat (2) @(negedge clk);
        check(sck_o == 1'b1 && !lead_o && !trail_o, "R2",
              $sformatf("idle after bursts sck=%0b expected 1", sck_o));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual cycle=%0d expected end before 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule